// File: doc/BRIEF.md
# NAND Flash Byte-Access Bridge

The block lets a processor drive an 8-bit raw NAND flash device through ordinary byte loads and stores. A request on a valid/ready bus either targets the bridge's own register space (top address bit set) or a NAND window. Inside the window, the low bits of the access address select which NAND control lines are active for that cycle. A store with the chip-select and command-latch bits becomes a command cycle. A store with the chip-select and address-latch bits becomes an address cycle. An access with only chip-select becomes a data cycle, either read or write.

Each NAND cycle runs through four phases: setup, strobe, hold and recovery. Their lengths come from a timing register counted in bus clock cycles. The bus is stalled for the whole cycle. Software then polls a sticky completion flag and the live ready/busy level in a status register. Further registers enable NAND mode and the chip enable, set the active level of the chip-select, spare-select and write-protect pins, route chip select to a second line, and place and mask the address window.

The request channel accepts only while the block is idle (`req_ready` high), so back-pressure on requests lasts for the whole of an access. Every accepted request, read or write, yields exactly one response beat. That beat is held with stable data until `rsp_ready` is high.

Top module: `nand_bus_bridge`

## Requirements
- R1: After reset, CONTROL (offset 0x0) reads 0, TIMING (offset 0x8) reads 0x00041122 (write wait 2, read wait 2, hold 1, recovery 1, multiplier 4), WINDOW (offset 0xC) reads 0, and STATUS (offset 0x4) reads only the ready/busy level in bit 0.
- R2: Register space is selected by address bit 15, with the register chosen by address bits 3:2. Only CONTROL bits 0,1,4,5,6,7,8,10,20 (mask 0x001005F3) and WINDOW bits 0,7:4,14:8 (mask 0x7FF1) are writable. Writes to STATUS are dropped. Writes return 0 on the response.
- R3: A non-register access hits the window only when WINDOW bit 0 is set and address bits 14:8 equal WINDOW bits 14:8, with address bits 11:8 ignored where WINDOW bits 7:4 are set. A miss causes no strobe and reads back 0.
- R4: NAND cycles run only while CONTROL bit 0 (NAND mode) and bit 20 (chip enable) are both set. Otherwise a window access causes no strobe and reads back 0.
- R5: During a NAND cycle, address bit 2 drives the address latch (active high), bit 3 the command latch (active high), bit 4 chip select, bit 5 spare select and bit 6 write protect. Outside a cycle all of them are inactive.
- R6: A write cycle drives the low data byte on the data pins with output enable and pulses `nand_we_n` low for max(write wait × multiplier, 1) cycles.
- R7: A read cycle pulses `nand_re_n` low for max(read wait × multiplier, 1) cycles and returns the data pins, sampled in the last low cycle, in response bits 7:0.
- R8: After the strobe, hold and recovery last max(hold,1) and max(recovery,1) cycles, then the response follows. `req_ready` stays low throughout.
- R9: STATUS bit 0 is the live ready/busy input. STATUS bit 3 is cleared when a NAND cycle is accepted and set when its recovery phase ends.
- R10: CONTROL bits 4, 5, 6 make chip select, spare select and write protect active-high when set, active-low when clear.
- R11: Chip select goes to line 1 instead of line 0 when CONTROL bit 10 is set (writes) or bit 8 is set (reads).
- R12: A response beat stays valid with stable data while `rsp_ready` is low.
- R13: `nand_we_n` and `nand_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (idle) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Store data (low byte for NAND) |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Load result, 0 for stores |
| nand_rb | input | 1 | Device ready/busy level |
| nand_dq_i | input | 8 | Data pins in |
| nand_dq_o | output | 8 | Data pins out |
| nand_dq_oe | output | 1 | Data pin drive enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ale | output | 1 | Address latch enable |
| nand_cle | output | 1 | Command latch enable |
| nand_cs | output | 2 | Chip-select lines |
| nand_se | output | 1 | Spare-area select |
| nand_wp | output | 1 | Write protect |

## Verification
A phase counter that loads the wrong length shows up as a strobe of the wrong width on `nand_we_n` or `nand_re_n`, or as the wrong gap between the strobe and the response. The bench measures both on the very cycle they occur. A corrupt latched address or control state shows up on the control pins during the same strobe, so every write strobe is compared field by field against an expected pin record. A stale completion flag or wrong decode becomes visible only at the next STATUS read or window read. Those are issued right after each NAND cycle, so such a fault is caught within one access.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
  localparam int REG_W = 32;

  localparam int CTRL_MODE   = 0;
  localparam int CTRL_CSPOL  = 4;
  localparam int CTRL_SEPOL  = 5;
  localparam int CTRL_WPPOL  = 6;
  localparam int CTRL_RDCS1  = 8;
  localparam int CTRL_WRCS1  = 10;
  localparam int CTRL_CHIPEN = 20;
  localparam logic [REG_W-1:0] CTRL_WMASK = 32'h0010_05F3;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_TIM  = 2'd2;
  localparam logic [1:0] SEL_WIN  = 2'd3;

  localparam int STAT_RB  = 0;
  localparam int STAT_CMP = 3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV, PH_RESP
  } phase_e;

  typedef struct packed {
    logic ale;
    logic cle;
    logic cs;
    logic se;
    logic wp;
  } lines_t;
endpackage

// File: rtl/nbb_regs.sv
module nbb_regs
  import nbb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int FIELD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             nand_rb,
  input  logic             cmp_clr,
  input  logic             cmp_set,
  output logic [REG_W-1:0] ctrl,
  output logic [REG_W-1:0] timing,
  output logic [REG_W-1:0] window,
  output logic [REG_W-1:0] rdata,
  output logic             cmp_flag
);
  localparam int TIM_BITS = 5 * FIELD_W;
  localparam logic [REG_W-1:0] TIM_MASK = REG_W'((64'd1 << TIM_BITS) - 64'd1);
  localparam logic [REG_W-1:0] TIM_RST =
    REG_W'({FIELD_W'(4), FIELD_W'(1), FIELD_W'(1), FIELD_W'(2), FIELD_W'(2)});
  localparam logic [REG_W-1:0] WIN_MASK =
    (REG_W'((64'd1 << (ADDR_W - 1)) - 64'd1) & ~REG_W'(8'hFF)) | REG_W'(8'hF1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      timing   <= TIM_RST;
      window   <= '0;
      cmp_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        case (sel)
          SEL_CTRL: ctrl   <= wdata & CTRL_WMASK;
          SEL_TIM:  timing <= wdata & TIM_MASK;
          SEL_WIN:  window <= wdata & WIN_MASK;
          default:  ;
        endcase
      end
      if (cmp_clr)      cmp_flag <= 1'b0;
      else if (cmp_set) cmp_flag <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_CTRL: rdata = ctrl;
      SEL_STAT: begin
        rdata[STAT_RB]  = nand_rb;
        rdata[STAT_CMP] = cmp_flag;
      end
      SEL_TIM:  rdata = timing;
      default:  rdata = window;
    endcase
  end
endmodule

// File: rtl/nbb_decode.sv
module nbb_decode
  import nbb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode_on,
  input  logic              chip_en,
  input  logic              win_en,
  input  logic [3:0]        win_mask,
  input  logic [ADDR_W-10:0] win_base,
  output logic              is_reg,
  output logic              nand_go,
  output logic [1:0]        reg_sel,
  output lines_t            lines
);
  localparam int BASE_W = ADDR_W - 9;

  logic [BASE_W-1:0] field;
  logic [BASE_W-1:0] care;
  logic              win_hit;
  logic [1:0]        unused_low;

  always_comb begin
    field     = addr[ADDR_W-2:8];
    care      = '1;
    care[3:0] = ~win_mask;
    is_reg    = addr[ADDR_W-1];
    win_hit   = !is_reg && win_en && (((field ^ win_base) & care) == '0);
    nand_go   = win_hit && mode_on && chip_en;
    reg_sel   = addr[3:2];
    lines.ale = addr[2];
    lines.cle = addr[3];
    lines.cs  = addr[4];
    lines.se  = addr[5];
    lines.wp  = addr[6];
  end

  assign unused_low = {addr[7], ^addr[1:0]};
endmodule

// File: rtl/nbb_seq.sv
module nbb_seq
  import nbb_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int CNT_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_nand,
  input  logic               start_direct,
  input  logic               is_write,
  input  logic               rsp_ready,
  input  logic [FIELD_W-1:0] wr_wait,
  input  logic [FIELD_W-1:0] rd_wait,
  input  logic [FIELD_W-1:0] hold,
  input  logic [FIELD_W-1:0] recov,
  input  logic [FIELD_W-1:0] mult,
  output phase_e             phase,
  output logic               strobe_last,
  output logic               done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] strobe_len;
  logic [CNT_W-1:0] hold_len;
  logic [CNT_W-1:0] recov_len;

  always_comb begin
    strobe_len = CNT_W'(is_write ? wr_wait : rd_wait) * CNT_W'(mult);
    if (strobe_len == '0) strobe_len = CNT_W'(1);
    hold_len  = (hold  == '0) ? CNT_W'(1) : CNT_W'(hold);
    recov_len = (recov == '0) ? CNT_W'(1) : CNT_W'(recov);
  end

  assign strobe_last = (phase == PH_STROBE) && (cnt == '0);
  assign done        = (phase == PH_RECOV) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start_nand)        phase <= PH_SETUP;
          else if (start_direct) phase <= PH_RESP;
        end
        PH_SETUP: begin
          phase <= PH_STROBE;
          cnt   <= strobe_len - CNT_W'(1);
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            phase <= PH_HOLD;
            cnt   <= hold_len - CNT_W'(1);
          end else cnt <= cnt - CNT_W'(1);
        end
        PH_HOLD: begin
          if (cnt == '0) begin
            phase <= PH_RECOV;
            cnt   <= recov_len - CNT_W'(1);
          end else cnt <= cnt - CNT_W'(1);
        end
        PH_RECOV: begin
          if (cnt == '0) phase <= PH_RESP;
          else           cnt   <= cnt - CNT_W'(1);
        end
        PH_RESP: if (rsp_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nbb_pins.sv
module nbb_pins
  import nbb_pkg::*;
#(
  parameter int CS_LINES = 2
) (
  input  phase_e              phase,
  input  logic                is_write,
  input  lines_t              lines,
  input  logic                cs_pol,
  input  logic                se_pol,
  input  logic                wp_pol,
  input  logic                rd_cs1,
  input  logic                wr_cs1,
  output logic                nand_we_n,
  output logic                nand_re_n,
  output logic                nand_ale,
  output logic                nand_cle,
  output logic                nand_se,
  output logic                nand_wp,
  output logic                nand_dq_oe,
  output logic [CS_LINES-1:0] nand_cs
);
  logic active;
  logic strobe;
  logic cs_idx;

  always_comb begin
    active     = (phase == PH_SETUP) || (phase == PH_STROBE) ||
                 (phase == PH_HOLD)  || (phase == PH_RECOV);
    strobe     = (phase == PH_STROBE);
    cs_idx     = is_write ? wr_cs1 : rd_cs1;
    nand_we_n  = !(strobe && is_write);
    nand_re_n  = !(strobe && !is_write);
    nand_ale   = active && lines.ale;
    nand_cle   = active && lines.cle;
    nand_se    = (active && lines.se) ? se_pol : !se_pol;
    nand_wp    = (active && lines.wp) ? wp_pol : !wp_pol;
    nand_dq_oe = active && is_write;
  end

  for (genvar g = 0; g < CS_LINES; g++) begin : g_cs
    assign nand_cs[g] = (active && lines.cs && (int'(cs_idx) == g)) ? cs_pol : !cs_pol;
  end
endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
  import nbb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int FIELD_W  = 4,
  parameter int CNT_W    = 10,
  parameter int CS_LINES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [REG_W-1:0]    req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [REG_W-1:0]    rsp_rdata,
  input  logic                nand_rb,
  input  logic [7:0]          nand_dq_i,
  output logic [7:0]          nand_dq_o,
  output logic                nand_dq_oe,
  output logic                nand_we_n,
  output logic                nand_re_n,
  output logic                nand_ale,
  output logic                nand_cle,
  output logic [CS_LINES-1:0] nand_cs,
  output logic                nand_se,
  output logic                nand_wp
);
  localparam int BASE_W = ADDR_W - 9;

  logic [REG_W-1:0] ctrl_q, tim_q, win_q, reg_rd;
  logic             cmp_flag;
  logic             is_reg, nand_go;
  logic [1:0]       reg_sel;
  lines_t           lines_d, lines_q;
  phase_e           phase;
  logic             strobe_last, seq_done;
  logic             accept, start_nand, start_direct;
  logic             wr_q;
  logic [7:0]       wdata_q;
  logic [REG_W-1:0] rdat_q;
  logic             unused_regs;

  assign req_ready    = (phase == PH_IDLE);
  assign rsp_valid    = (phase == PH_RESP);
  assign accept       = req_valid && req_ready;
  assign start_nand   = accept && nand_go;
  assign start_direct = accept && !nand_go;
  assign rsp_rdata    = rdat_q;
  assign nand_dq_o    = wdata_q;

  nbb_regs #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept && is_reg && req_write),
    .sel      (reg_sel),
    .wdata    (req_wdata),
    .nand_rb  (nand_rb),
    .cmp_clr  (start_nand),
    .cmp_set  (seq_done),
    .ctrl     (ctrl_q),
    .timing   (tim_q),
    .window   (win_q),
    .rdata    (reg_rd),
    .cmp_flag (cmp_flag)
  );

  nbb_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr     (req_addr),
    .mode_on  (ctrl_q[CTRL_MODE]),
    .chip_en  (ctrl_q[CTRL_CHIPEN]),
    .win_en   (win_q[0]),
    .win_mask (win_q[7:4]),
    .win_base (win_q[8 +: BASE_W]),
    .is_reg   (is_reg),
    .nand_go  (nand_go),
    .reg_sel  (reg_sel),
    .lines    (lines_d)
  );

  nbb_seq #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_nand   (start_nand),
    .start_direct (start_direct),
    .is_write     (wr_q),
    .rsp_ready    (rsp_ready),
    .wr_wait      (tim_q[0*FIELD_W +: FIELD_W]),
    .rd_wait      (tim_q[1*FIELD_W +: FIELD_W]),
    .hold         (tim_q[2*FIELD_W +: FIELD_W]),
    .recov        (tim_q[3*FIELD_W +: FIELD_W]),
    .mult         (tim_q[4*FIELD_W +: FIELD_W]),
    .phase        (phase),
    .strobe_last  (strobe_last),
    .done         (seq_done)
  );

  nbb_pins #(.CS_LINES(CS_LINES)) u_pins (
    .phase      (phase),
    .is_write   (wr_q),
    .lines      (lines_q),
    .cs_pol     (ctrl_q[CTRL_CSPOL]),
    .se_pol     (ctrl_q[CTRL_SEPOL]),
    .wp_pol     (ctrl_q[CTRL_WPPOL]),
    .rd_cs1     (ctrl_q[CTRL_RDCS1]),
    .wr_cs1     (ctrl_q[CTRL_WRCS1]),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_ale   (nand_ale),
    .nand_cle   (nand_cle),
    .nand_se    (nand_se),
    .nand_wp    (nand_wp),
    .nand_dq_oe (nand_dq_oe),
    .nand_cs    (nand_cs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wdata_q <= '0;
      lines_q <= '0;
      rdat_q  <= '0;
    end else begin
      if (accept) begin
        wr_q    <= req_write;
        wdata_q <= req_wdata[7:0];
        lines_q <= lines_d;
        rdat_q  <= (is_reg && !req_write) ? reg_rd : '0;
      end else if (strobe_last && !wr_q) begin
        rdat_q <= {{(REG_W-8){1'b0}}, nand_dq_i};
      end
    end
  end

  assign unused_regs = ^{ctrl_q, tim_q, win_q};
endmodule

// File: rtl/nbb_checker.sv
module nbb_checker
  import nbb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [REG_W-1:0] rsp_rdata,
  input logic             nand_we_n,
  input logic             nand_re_n,
  input logic             nand_dq_oe,
  input logic [REG_W-1:0] ctrl,
  input logic             cmp_flag,
  input logic             start_nand
);
  assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> (ctrl[CTRL_MODE] && ctrl[CTRL_CHIPEN]));

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !req_ready);

  assert_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  assert_cmp_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_nand |=> !cmp_flag);

  assert_cmp_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> (nand_we_n && nand_re_n));
endmodule

bind nand_bus_bridge nbb_checker u_nbb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe),
  .ctrl       (ctrl_q),
  .cmp_flag   (cmp_flag),
  .start_nand (start_nand)
);

// File: tb/tb_nand_bus_bridge.sv
`timescale 1ns/1ps
module tb_nand_bus_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        nand_rb = 1'b1;
  logic [7:0]  nand_dq_i = '0;
  logic [7:0]  nand_dq_o;
  logic        nand_dq_oe, nand_we_n, nand_re_n, nand_ale, nand_cle, nand_se, nand_wp;
  logic [1:0]  nand_cs;

  always #2.5 clk = ~clk;

  nand_bus_bridge dut (.*);

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] pin_q[$];
  string       ptag_q[$];
  int rsp_cnt = 0, wr_caps = 0, rd_caps = 0;
  int we_w = 0, re_w = 0, last_re_w = 0, after = 0, last_gap = 0;
  logic [31:0] cur_pins;
  logic [1:0]  rd_cs;
  bit          stall_bad = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  function automatic logic [31:0] pw(logic [7:0] dq, logic cle, logic ale, logic [1:0] cs,
                                     logic se, logic wp, int w);
    return {8'd0, 8'(w), 2'b00, wp, se, cs, ale, cle, dq};
  endfunction

  // monitor: scoreboard pops on response, pin records on write strobe end
  always @(negedge clk) if (rst_n) begin
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(0, "R12 unexpected response", rsp_rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata == e, t, rsp_rdata, e);
      end
      rsp_cnt++;
      if (after > 0) begin last_gap = after; after = 0; end
    end else if (after > 0) after++;
    if ((!nand_we_n || !nand_re_n) && req_ready) stall_bad = 1;
    if (!nand_we_n) begin
      we_w++;
      cur_pins = pw(nand_dq_o, nand_cle, nand_ale, nand_cs, nand_se, nand_wp, we_w);
    end else if (we_w > 0) begin
      wr_caps++;
      we_w = 0;
      after = 1;
      if (pin_q.size() == 0) chk(0, "R3 unexpected write strobe", cur_pins, 0);
      else begin
        logic [31:0] e;
        string t;
        e = pin_q.pop_front();
        t = ptag_q.pop_front();
        chk(cur_pins == e, t, cur_pins, e);
      end
    end
    if (!nand_re_n) begin re_w++; rd_cs = nand_cs; end
    else if (re_w > 0) begin last_re_w = re_w; re_w = 0; rd_caps++; end
  end

  task automatic bus(input bit wr, input logic [15:0] a, input logic [31:0] d,
                     input logic [31:0] expv, input string rq);
    int start;
    start = rsp_cnt;
    exp_q.push_back(expv);
    tag_q.push_back(rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (rsp_cnt == start) @(negedge clk);
  endtask

  task automatic nwrite(input logic [15:0] a, input logic [7:0] d, input logic [31:0] pins,
                        input string rq);
    pin_q.push_back(pins);
    ptag_q.push_back(rq);
    bus(1'b1, a, {24'd0, d}, 32'd0, rq);
    chk(pin_q.size() == 0, {rq, " strobe seen"}, pin_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    bus(0, 16'h8000, 0, 32'h0, "R1 CONTROL reset");
    bus(0, 16'h8004, 0, 32'h1, "R1 STATUS reset");
    bus(0, 16'h8008, 0, 32'h0004_1122, "R1 TIMING reset");
    bus(0, 16'h800C, 0, 32'h0, "R1 WINDOW reset");
    // R3 window disabled: ignored
    n = wr_caps;
    bus(1, 16'h1018, 32'h90, 0, "R3 write ignored");
    chk(wr_caps == n, "R3 no strobe when window off", wr_caps, n);
    // R2 masks
    bus(1, 16'h800C, 32'hFFFF_FFFF, 0, "R2 window write");
    bus(0, 16'h800C, 0, 32'h0000_7FF1, "R2 WINDOW mask");
    bus(1, 16'h8000, 32'hFFFF_FFFF, 0, "R2 ctrl write");
    bus(0, 16'h8000, 0, 32'h0010_05F3, "R2 CONTROL mask");
    bus(1, 16'h8004, 32'hFFFF_FFFF, 0, "R2 status write");
    bus(0, 16'h8004, 0, 32'h1, "R2 STATUS unchanged");
    bus(1, 16'h800C, 32'h0000_1001, 0, "R3 window base 0x10");
    bus(1, 16'h8000, 32'h0010_0001, 0, "R4 mode and chip enable");
    // R5 R6 command and address cycles
    nwrite(16'h1018, 8'h90, pw(8'h90, 1, 0, 2'b10, 1, 1, 8), "R5 command cycle pins");
    chk(last_gap == 2, "R8 hold+recovery gap", last_gap, 2);
    nwrite(16'h1014, 8'h3C, pw(8'h3C, 0, 1, 2'b10, 1, 1, 8), "R5 address cycle pins");
    bus(0, 16'h8004, 0, 32'h9, "R9 complete and ready");
    nand_rb = 1'b0;
    bus(0, 16'h8004, 0, 32'h8, "R9 busy level");
    nand_rb = 1'b1;
    // R7 read
    nand_dq_i = 8'h5A;
    bus(0, 16'h1010, 0, 32'h5A, "R7 read data");
    chk(last_re_w == 8, "R7 read strobe width", last_re_w, 8);
    chk(rd_cs == 2'b10, "R11 read on line 0", rd_cs, 2'b10);
    // R3 window miss and mask
    n = wr_caps;
    bus(1, 16'h2018, 32'h11, 0, "R3 miss write");
    chk(wr_caps == n, "R3 no strobe on miss", wr_caps, n);
    bus(0, 16'h2010, 0, 32'h0, "R3 miss read zero");
    bus(1, 16'h800C, 32'h0000_1011, 0, "R3 window mask");
    bus(0, 16'h1110, 0, 32'h5A, "R3 masked bit hit");
    // R6 R8 timing: wr 3, rd 1, hold 2, recov 3, mult 1
    bus(1, 16'h8008, 32'h0001_3213, 0, "R6 timing write");
    nwrite(16'h1010, 8'hA7, pw(8'hA7, 0, 0, 2'b10, 1, 1, 3), "R6 data write width");
    chk(last_gap == 5, "R8 longer hold+recovery", last_gap, 5);
    bus(0, 16'h1010, 0, 32'h5A, "R7 short read");
    chk(last_re_w == 1, "R7 read width one", last_re_w, 1);
    // R10 polarity
    bus(1, 16'h8000, 32'h0010_0071, 0, "R10 polarity set");
    nwrite(16'h1070, 8'h11, pw(8'h11, 0, 0, 2'b01, 1, 1, 3), "R10 active-high pins");
    nwrite(16'h1010, 8'h22, pw(8'h22, 0, 0, 2'b01, 0, 0, 3), "R10 inactive se wp");
    // R11 routing
    bus(1, 16'h8000, 32'h0010_0471, 0, "R11 write route");
    nwrite(16'h1010, 8'h33, pw(8'h33, 0, 0, 2'b10, 0, 0, 3), "R11 write on line 1");
    bus(0, 16'h1010, 0, 32'h5A, "R11 read");
    chk(rd_cs == 2'b01, "R11 read stays line 0", rd_cs, 2'b01);
    bus(1, 16'h8000, 32'h0010_0171, 0, "R11 read route");
    bus(0, 16'h1010, 0, 32'h5A, "R11 read");
    chk(rd_cs == 2'b10, "R11 read on line 1", rd_cs, 2'b10);
    // R4 gating
    bus(1, 16'h8000, 32'h0010_0000, 0, "R4 mode off");
    n = wr_caps;
    bus(1, 16'h1018, 32'h44, 0, "R4 write mode off");
    chk(wr_caps == n, "R4 no strobe mode off", wr_caps, n);
    bus(0, 16'h1010, 0, 32'h0, "R4 read zero mode off");
    bus(1, 16'h8000, 32'h0000_0001, 0, "R4 chip enable off");
    n = rd_caps;
    bus(0, 16'h1010, 0, 32'h0, "R4 read zero ce off");
    chk(rd_caps == n, "R4 no read strobe ce off", rd_caps, n);
    // R12 back-pressure
    rsp_ready = 1'b0;
    fork
      bus(0, 16'h8008, 0, 32'h0001_3213, "R12 held response");
    join_none
    repeat (6) @(negedge clk);
    chk(rsp_valid == 1'b1, "R12 valid held", rsp_valid, 1);
    chk(rsp_rdata == 32'h0001_3213, "R12 data held", rsp_rdata, 32'h0001_3213);
    chk(req_ready == 1'b0, "R12 no accept while held", req_ready, 0);
    rsp_ready = 1'b1;
    wait fork;
    chk(!stall_bad, "R8 req_ready low during strobes", stall_bad, 0);
    chk(exp_q.size() == 0, "R12 all responses seen", exp_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule